// File: doc/BRIEF.md
# Windowed watchdog with reset escalation

This block is a watchdog that counts system clock cycles and must be serviced by software within a permitted window. A clear strobe that comes too late lets the count run past the end of the selected period. A clear that comes before a programmed minimum interval has elapsed is also treated as misbehaviour. Either kind of fault raises a single-cycle non-maskable interrupt request. If a second fault follows the first with no valid service in between, the block raises a system reset request instead of a second interrupt.

Software writes a small control word that holds a run bit, a period select and a minimum-interval select. The block leaves reset stopped. The first write with the run bit set starts it, and from that point the whole control word is frozen until the next reset. This stops a runaway program from halting the watchdog or widening its window. The register bus decode, the interrupt controller and the reset generator sit outside the block.

Top module: `wdog_window`

## Requirements
- R1: After `rst` the watchdog is stopped, `nmi_o` and `rst_req_o` are low, and while stopped neither time nor `clr_i` pulses produce any fault.
- R2: A write (`cfg_we_i` high) while stopped latches `cfg_tsel_i` and `cfg_msel_i`. With `cfg_run_i`=1 the count starts from zero at that edge and rises by one on every later clock edge. With `cfg_run_i`=0 the watchdog stays stopped.
- R3: `cfg_tsel_i` values 0, 1, 2 and 3 select periods P of 2^10, 2^12, 2^14 and 2^16 cycles. An overflow fault occurs on the P-th clock edge after the count last started from zero, unless a clear arrives on that edge.
- R4: Once running, no write can stop the watchdog. Only `rst` does.
- R5: Writes while running are ignored in full, including any new `cfg_tsel_i` or `cfg_msel_i`.
- R6: `cfg_msel_i` values 0, 1, 2 and 3 set the minimum count at clear to 0, P/8, P/4 and P/2. A clear taken while the count is below that minimum is an early fault.
- R7: A clear taken with the count at or above the minimum is valid, including at count P-1 on the edge that would otherwise overflow. A valid clear returns the count to zero and raises no fault.
- R8: Every fault returns the count to zero, so the next overflow comes P edges later.
- R9: A fault with no earlier unserviced fault raises `nmi_o` for exactly one cycle, starting in the cycle after the faulting edge.
- R10: A fault that follows an earlier fault with no valid clear between them raises `rst_req_o` in the cycle after the faulting edge and does not pulse `nmi_o`. `rst_req_o` stays high until `rst`.
- R11: A valid clear wipes the fault history, so the next fault after it raises `nmi_o` again rather than `rst_req_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the count source |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we_i | input | 1 | Control word write strobe |
| cfg_run_i | input | 1 | Run bit of the control word |
| cfg_tsel_i | input | 2 | Period select (0..3 -> 2^10..2^16 cycles) |
| cfg_msel_i | input | 2 | Minimum-clear select (0: none, 1: P/8, 2: P/4, 3: P/2) |
| clr_i | input | 1 | Service strobe, one cycle per clear |
| nmi_o | output | 1 | Non-maskable interrupt request, one-cycle pulse per first fault |
| rst_req_o | output | 1 | System reset request, held until reset |

## Verification
Overflow detection and service can land on the same edge. This happens when the clear arrives just as the count stands at P-1. The bench lets the count run to exactly P-1 and strobes the clear on that edge. It then expects no interrupt, and it expects the next overflow a full period later, which shows the clear took priority and restarted the count. A second such collision comes from two early clears a few cycles apart. There the fault history set by the first fault meets the new fault, and the bench expects the reset request with no interrupt pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        MIN_NONE    = 2'd0,
        MIN_EIGHTH  = 2'd1,
        MIN_QUARTER = 2'd2,
        MIN_HALF    = 2'd3
    } min_sel_e;

    typedef struct packed {
        logic       run;
        logic [1:0] tsel;
        min_sel_e   msel;
    } wd_cfg_t;

    typedef struct packed {
        logic overflow;
        logic early;
        logic good;
    } wd_evt_t;

    function automatic int unsigned period_log2(int unsigned base, int unsigned step,
                                                logic [1:0] tsel);
        return base + step * 32'(tsel);
    endfunction

    function automatic int unsigned last_count(int unsigned base, int unsigned step,
                                               logic [1:0] tsel);
        return (32'd1 << period_log2(base, step, tsel)) - 32'd1;
    endfunction

    function automatic int unsigned min_count(int unsigned base, int unsigned step,
                                              logic [1:0] tsel, min_sel_e msel);
        if (msel == MIN_NONE) return 32'd0;
        return 32'd1 << (period_log2(base, step, tsel) - 32'd4 + 32'(msel));
    endfunction

endpackage

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       we,
    input  logic       run_in,
    input  logic [1:0] tsel_in,
    input  logic [1:0] msel_in,
    output wd_cfg_t    cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.run  <= 1'b0;
            cfg.tsel <= 2'd0;
            cfg.msel <= MIN_NONE;
        end else if (we && !cfg.run) begin
            cfg.run  <= run_in;
            cfg.tsel <= tsel_in;
            cfg.msel <= min_sel_e'(msel_in);
        end
    end

    assert_run_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        cfg.run |=> cfg.run);

    assert_sel_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        cfg.run |=> ($stable(cfg.tsel) && $stable(cfg.msel)));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 10,
    parameter int unsigned STEP_LOG2 = 2,
    parameter int unsigned CW        = BASE_LOG2 + 3 * STEP_LOG2
) (
    input  logic    clk,
    input  logic    rst,
    input  wd_cfg_t cfg,
    input  logic    clr,
    output wd_evt_t evt
);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;
    logic [CW-1:0] floor_v;

    always_comb begin
        limit   = CW'(last_count(BASE_LOG2, STEP_LOG2, cfg.tsel));
        floor_v = CW'(min_count(BASE_LOG2, STEP_LOG2, cfg.tsel, cfg.msel));
    end

    // a clear on the last count is valid and so beats the overflow
    always_comb begin
        evt = '0;
        if (cfg.run) begin
            if (clr) begin
                if (cnt < floor_v) evt.early = 1'b1;
                else               evt.good  = 1'b1;
            end else if (cnt == limit) begin
                evt.overflow = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cfg.run) begin
            if (evt != '0) cnt <= '0;
            else           cnt <= cnt + 1'b1;
        end
    end

    assert_idle_count_R1: assert property (@(posedge clk) disable iff (rst)
        !cfg.run |-> (cnt == '0));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        cfg.run |-> (cnt <= limit));

    assert_fault_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (evt.overflow || evt.early) |=> (cnt == '0));

endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate
    import wdog_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  wd_evt_t evt,
    output logic    nmi_o,
    output logic    rst_req_o
);

    logic fault;
    logic strike;

    always_comb fault = evt.overflow | evt.early;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_o     <= 1'b0;
            rst_req_o <= 1'b0;
            strike    <= 1'b0;
        end else begin
            nmi_o <= fault && !strike;
            if (fault) begin
                if (strike) rst_req_o <= 1'b1;
                strike <= 1'b1;
            end else if (evt.good) begin
                strike <= 1'b0;
            end
        end
    end

    assert_nmi_after_fault_R9: assert property (@(posedge clk) disable iff (rst)
        (fault && !strike) |=> nmi_o);

    assert_nmi_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        nmi_o |=> !nmi_o);

    assert_req_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        rst_req_o |=> rst_req_o);

    assert_no_nmi_on_escalate_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(rst_req_o) |-> !nmi_o);

    assert_history_wipe_R11: assert property (@(posedge clk) disable iff (rst)
        (evt.good && !fault) |=> !strike);

endmodule

// File: rtl/wdog_window.sv
module wdog_window
    import wdog_pkg::*;
#(
    parameter int unsigned BASE_LOG2 = 10,
    parameter int unsigned STEP_LOG2 = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we_i,
    input  logic       cfg_run_i,
    input  logic [1:0] cfg_tsel_i,
    input  logic [1:0] cfg_msel_i,
    input  logic       clr_i,
    output logic       nmi_o,
    output logic       rst_req_o
);

    localparam int unsigned CW = BASE_LOG2 + 3 * STEP_LOG2;

    wd_cfg_t cfg;
    wd_evt_t evt;

    wdog_cfg u_cfg (
        .clk     (clk),
        .rst     (rst),
        .we      (cfg_we_i),
        .run_in  (cfg_run_i),
        .tsel_in (cfg_tsel_i),
        .msel_in (cfg_msel_i),
        .cfg     (cfg)
    );

    wdog_counter #(
        .BASE_LOG2 (BASE_LOG2),
        .STEP_LOG2 (STEP_LOG2),
        .CW        (CW)
    ) u_counter (
        .clk (clk),
        .rst (rst),
        .cfg (cfg),
        .clr (clr_i),
        .evt (evt)
    );

    wdog_escalate u_escalate (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .nmi_o     (nmi_o),
        .rst_req_o (rst_req_o)
    );

endmodule

// File: tb/wdog_window_tb_top.sv
module wdog_window_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 120000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic       cfg_run = 1'b0;
    logic [1:0] cfg_tsel = 2'd0;
    logic [1:0] cfg_msel = 2'd0;
    logic       clr = 1'b0;
    logic       nmi;
    logic       rst_req;

    int n_vec = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wdog_window dut_i (
        .clk        (clk),
        .rst        (rst),
        .cfg_we_i   (cfg_we),
        .cfg_run_i  (cfg_run),
        .cfg_tsel_i (cfg_tsel),
        .cfg_msel_i (cfg_msel),
        .clr_i      (clr),
        .nmi_o      (nmi),
        .rst_req_o  (rst_req)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_watch(input int n, output int pulses);
        pulses = 0;
        repeat (n) begin
            @(negedge clk);
            if (nmi) pulses++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cfg_we = 1'b0;
        clr = 1'b0;
        run(2);
        rst = 1'b0;
    endtask

    // one edge; when it starts the watchdog the count is zero on return
    task automatic cfg_write(input logic run_b, input logic [1:0] tsel, input logic [1:0] msel);
        cfg_we = 1'b1;
        cfg_run = run_b;
        cfg_tsel = tsel;
        cfg_msel = msel;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_clr();
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    task automatic t_reset_idle();
        int p;
        int total;
        do_reset();
        check("R1", "nmi after reset", nmi, 0);
        check("R1", "rst_req after reset", rst_req, 0);
        total = 0;
        repeat (2) begin
            pulse_clr();
            run_watch(1100, p);
            total += p;
        end
        check("R1", "pulses while stopped", total, 0);
        cfg_write(1'b0, 2'd0, 2'd1);
        pulse_clr();
        run_watch(1100, p);
        check("R2", "pulses after write without run bit", p, 0);
        check("R2", "rst_req after write without run bit", rst_req, 0);
    endtask

    task automatic t_overflow_escalate();
        int p;
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd0);
        run_watch(1023, p);
        check("R3", "pulses before overflow", p, 0);
        run(1);
        check("R9", "nmi on overflow", nmi, 1);
        check("R9", "rst_req on first fault", rst_req, 0);
        run(1);
        check("R9", "nmi one cycle only", nmi, 0);
        run_watch(1022, p);
        check("R8", "pulses before second overflow", p, 0);
        check("R8", "rst_req before second overflow", rst_req, 0);
        run(1);
        check("R10", "rst_req on second fault", rst_req, 1);
        check("R10", "no nmi on second fault", nmi, 0);
        run_watch(200, p);
        check("R10", "pulses after escalation", p, 0);
        check("R10", "rst_req held", rst_req, 1);
        do_reset();
        check("R1", "rst_req dropped by reset", rst_req, 0);
    endtask

    task automatic t_keepalive();
        int p;
        int total;
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd0);
        total = 0;
        repeat (6) begin
            run_watch(900, p);
            total += p;
            pulse_clr();
            if (nmi) total++;
        end
        check("R7", "pulses with regular service", total, 0);
        check("R7", "rst_req with regular service", rst_req, 0);
    endtask

    task automatic t_last_count();
        int p;
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd0);
        run(1023);
        pulse_clr();
        check("R7", "clear at last count no nmi", nmi, 0);
        run_watch(1023, p);
        check("R7", "count restarted by clear", p, 0);
        run(1);
        check("R7", "overflow a full period after clear", nmi, 1);
    endtask

    task automatic t_early_history();
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd2);
        run(100);
        pulse_clr();
        check("R6", "early clear raises nmi", nmi, 1);
        run(300);
        pulse_clr();
        check("R7", "clear inside window no nmi", nmi, 0);
        check("R7", "clear inside window no rst_req", rst_req, 0);
        run(50);
        pulse_clr();
        check("R11", "history wiped, nmi again", nmi, 1);
        check("R11", "history wiped, no rst_req", rst_req, 0);
        run(10);
        pulse_clr();
        check("R10", "second early fault rst_req", rst_req, 1);
        check("R10", "second early fault no nmi", nmi, 0);
    endtask

    task automatic t_fault_restart();
        int p;
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd1);
        run(5);
        pulse_clr();
        check("R6", "early clear under eighth", nmi, 1);
        run_watch(1023, p);
        check("R8", "rst_req before period after fault", rst_req, 0);
        run(1);
        check("R8", "overflow one period after fault", rst_req, 1);
    endtask

    task automatic t_min_edge();
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd1);
        run(128);
        pulse_clr();
        check("R6", "clear at minimum is valid", nmi, 0);
        run(127);
        pulse_clr();
        check("R6", "clear one below minimum faults", nmi, 1);
    endtask

    task automatic t_lock();
        int p;
        do_reset();
        cfg_write(1'b1, 2'd0, 2'd0);
        run(10);
        cfg_write(1'b0, 2'd3, 2'd3);
        run_watch(1012, p);
        check("R4", "pulses after stop attempt", p, 0);
        run(1);
        check("R4", "still running after stop write", nmi, 1);
        check("R5", "period not widened", nmi, 1);
        run(20);
        pulse_clr();
        check("R5", "minimum not raised, no nmi", nmi, 0);
        check("R5", "minimum not raised, no rst_req", rst_req, 0);
    endtask

    task automatic t_long_period();
        int p;
        do_reset();
        cfg_write(1'b1, 2'd1, 2'd3);
        run_watch(4095, p);
        check("R3", "no fault before 4096 edges", p, 0);
        run(1);
        check("R3", "overflow at 4096 edges", nmi, 1);
        run(2048);
        pulse_clr();
        check("R6", "clear at half period valid", nmi, 0);
        run(2047);
        pulse_clr();
        check("R6", "clear below half period faults", nmi, 1);
        check("R11", "no rst_req after wiped history", rst_req, 0);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WATCHDOG_CYCLES, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        t_reset_idle();
        t_overflow_escalate();
        t_keepalive();
        t_last_count();
        t_early_history();
        t_fault_restart();
        t_min_edge();
        t_lock();
        t_long_period();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule